// File: doc/BRIEF.md
# Circular Fault Record Ring

This block captures translation-fault events into a small ring of fixed-size records. Each record holds four 32-bit words: words 0 to 2 and bits 30:0 of word 3 carry the fault payload, and bit 31 of word 3 is the record's valid flag. A hidden write index selects the slot for the next fault. A fault is stored only when the slot under that index is free. If the slot is still valid, the fault is dropped and an overflow flag is raised, even when other slots in the ring are empty.

Software services the ring in circular order. It starts at the first-index field of the status register and stops at the first record whose flag is clear. It releases a record by writing 1 to that record's flag bit. A status register reports the overflow flag, a pending flag and the first-index field. A capability register reports the ring depth. A one-cycle interrupt pulse marks the first recording after each acknowledge, and any status write acknowledges.

Top module: `fault_ring`

## Requirements
- R1: After reset, all record words read 0. The status register reads 0, `irq_o` is low, and the capability register (address 1) reads NUM_REC.
- R2: A recorded fault with payload P goes into slot s. Words 0, 1 and 2 of slot s, at addresses 4+4s+0, 4+4s+1 and 4+4s+2, read P[31:0], P[63:32] and P[95:64]. Word 3, at address 4+4s+3, reads {1, P[126:96]}.
- R3: The write index starts at 0. It advances by one after each recording and wraps to 0 after slot NUM_REC-1. It does not move when a fault is dropped.
- R4: A fault that finds the slot under the write index valid is dropped, even if other slots are free. Every stored record is left unchanged.
- R5: Status bit 0 (overflow) is set when a fault is dropped. A status write (address 0) with data bit 0 = 1 clears it. A drop in the same cycle as that write leaves it set.
- R6: Status bit 1 (pending) is 1 exactly when at least one record's flag is set.
- R7: Status bits [8 +: log2(NUM_REC)] hold the slot of the first fault recorded since the last status write.
- R8: `irq_o` is high for one cycle, in the cycle after a recording, when no interrupt is outstanding. Any write to address 0 acknowledges the outstanding interrupt, including a write in the same cycle as the recording.
- R9: A write of data bit 31 = 1 to word 3 of a slot clears that slot's flag. Writes to word 3 with bit 31 = 0, and writes to words 0 to 2, change nothing.
- R10: A fault that arrives in the same cycle as the clear of the slot under the write index is recorded into that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | A fault event is presented this cycle |
| flt_payload | input | 127 | Fault payload stored into the record |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (5 at default) | Word address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The bench looks first at the stale-slot case: a cleared slot ahead of the index while the indexed slot stays valid. A design that tracked only occupancy would record the fault there and leave overflow clear. It also exercises a clear and a fault landing on the indexed slot in the same cycle; a design that gave the stored flag precedence would drop the fault and raise overflow falsely. Wrap of the index, an acknowledge in the same cycle as a recording, and writes with the wrong bit or to the wrong word are swept against a cycle model. A misplaced wrap, a missed interrupt, a too-eager interrupt, or a write decoded too loosely each shows up as a record, status or interrupt mismatch.

// File: rtl/fault_ring_pkg.sv
package fault_ring_pkg;
   localparam int WORD_W       = 32;
   localparam int REC_WORDS    = 4;
   localparam int FLAG_BIT     = 31;
   localparam int PAYLOAD_W    = REC_WORDS * WORD_W - 1;
   localparam int STS_OVF_BIT  = 0;
   localparam int STS_PEND_BIT = 1;
   localparam int STS_IDX_LSB  = 8;
   localparam int ADDR_STATUS  = 0;
   localparam int ADDR_CAP     = 1;
   localparam int REC_BASE     = 4;
   localparam int MAX_REC      = 64;
endpackage

// File: rtl/fault_ring_store.sv
module fault_ring_store
   import fault_ring_pkg::*;
#(
   parameter int NUM_REC = 4,
   localparam int IDX_W = $clog2(NUM_REC)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic [PAYLOAD_W-1:0] wr_payload,
   input  logic [NUM_REC-1:0]   clr_vec,
   output logic [NUM_REC-1:0]   valid_o,
   output logic [PAYLOAD_W-1:0] payload_o [NUM_REC]
);
   for (genvar s = 0; s < NUM_REC; s++) begin : g_slot
      logic                 hit;
      logic                 vld_q;
      logic [PAYLOAD_W-1:0] pay_q;

      assign hit = wr_en && (wr_idx == IDX_W'(s));

      // the clear is applied first, so a same-cycle write wins
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            pay_q <= '0;
         end else begin
            if (hit) begin
               vld_q <= 1'b1;
               pay_q <= wr_payload;
            end else if (clr_vec[s]) begin
               vld_q <= 1'b0;
            end
         end
      end

      assign valid_o[s]   = vld_q;
      assign payload_o[s] = pay_q;
   end
endmodule

// File: rtl/fault_ring_ctrl.sv
module fault_ring_ctrl
   import fault_ring_pkg::*;
#(
   parameter int NUM_REC = 4,
   localparam int IDX_W = $clog2(NUM_REC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flt_valid,
   input  logic [NUM_REC-1:0] valid_i,
   input  logic [NUM_REC-1:0] clr_vec,
   input  logic               sts_wr,
   input  logic               ovf_w1c,
   output logic               rec_en,
   output logic [IDX_W-1:0]   wr_idx,
   output logic               ovf,
   output logic               pend,
   output logic [IDX_W-1:0]   first_idx,
   output logic               irq
);
   logic             slot_busy;
   logic             drop;
   logic [IDX_W-1:0] idx_next;
   logic             out_q;
   logic             out_eff;

   // busy only if the indexed slot stays valid after this cycle's clear
   assign slot_busy = valid_i[wr_idx] && !clr_vec[wr_idx];
   assign rec_en    = flt_valid && !slot_busy;
   assign drop      = flt_valid && slot_busy;
   assign pend      = |valid_i;
   assign out_eff   = out_q && !sts_wr;

   if ((NUM_REC & (NUM_REC - 1)) == 0) begin : g_wrap_pow2
      assign idx_next = wr_idx + IDX_W'(1);
   end else begin : g_wrap_cmp
      assign idx_next = (wr_idx == IDX_W'(NUM_REC - 1)) ? '0 : wr_idx + IDX_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_idx    <= '0;
         ovf       <= 1'b0;
         first_idx <= '0;
         out_q     <= 1'b0;
         irq       <= 1'b0;
      end else begin
         if (rec_en) wr_idx <= idx_next;
         if (drop) ovf <= 1'b1;
         else if (ovf_w1c) ovf <= 1'b0;
         irq   <= rec_en && !out_eff;
         out_q <= out_eff || rec_en;
         if (rec_en && !out_eff) first_idx <= wr_idx;
      end
   end
endmodule

// File: rtl/fault_ring_regs.sv
module fault_ring_regs
   import fault_ring_pkg::*;
#(
   parameter int NUM_REC = 4,
   localparam int IDX_W  = $clog2(NUM_REC),
   localparam int ADDR_W = $clog2(REC_BASE + REC_WORDS * NUM_REC),
   localparam int SLOT_W = ADDR_W - 2
) (
   input  logic                 reg_we,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [WORD_W-1:0]    reg_wdata,
   input  logic [NUM_REC-1:0]   valid_i,
   input  logic [PAYLOAD_W-1:0] payload_i [NUM_REC],
   input  logic                 ovf,
   input  logic                 pend,
   input  logic [IDX_W-1:0]     first_idx,
   output logic [WORD_W-1:0]    reg_rdata,
   output logic [NUM_REC-1:0]   clr_vec,
   output logic                 sts_wr,
   output logic                 ovf_w1c
);
   logic [ADDR_W-1:0] rel;
   logic [SLOT_W-1:0] slot_sel;
   logic [1:0]        word_sel;
   logic              rec_hit;
   logic              wdata_unused;
   logic [WORD_W-1:0] slot_words [NUM_REC][REC_WORDS];

   assign rel      = reg_addr - ADDR_W'(REC_BASE);
   assign slot_sel = rel[ADDR_W-1:2];
   assign word_sel = rel[1:0];
   assign rec_hit  = (reg_addr >= ADDR_W'(REC_BASE)) && (int'(slot_sel) < NUM_REC);
   assign sts_wr   = reg_we && (reg_addr == ADDR_W'(ADDR_STATUS));
   assign ovf_w1c  = sts_wr && reg_wdata[STS_OVF_BIT];
   assign wdata_unused = ^reg_wdata;

   for (genvar s = 0; s < NUM_REC; s++) begin : g_slot
      for (genvar w = 0; w < REC_WORDS - 1; w++) begin : g_word
         assign slot_words[s][w] = payload_i[s][w*WORD_W +: WORD_W];
      end
      assign slot_words[s][REC_WORDS-1] =
         {valid_i[s], payload_i[s][PAYLOAD_W-1 : (REC_WORDS-1)*WORD_W]};
      assign clr_vec[s] = reg_we && rec_hit && (slot_sel == SLOT_W'(s))
                          && (word_sel == 2'(REC_WORDS - 1)) && reg_wdata[FLAG_BIT];
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(ADDR_STATUS)) begin
         reg_rdata[STS_OVF_BIT]              = ovf;
         reg_rdata[STS_PEND_BIT]             = pend;
         reg_rdata[STS_IDX_LSB +: IDX_W]     = first_idx;
      end else if (reg_addr == ADDR_W'(ADDR_CAP)) begin
         reg_rdata = WORD_W'(NUM_REC);
      end else if (rec_hit) begin
         for (int s = 0; s < NUM_REC; s++) begin
            if (slot_sel == SLOT_W'(s)) reg_rdata = slot_words[s][word_sel];
         end
      end
   end
endmodule

// File: rtl/fault_ring.sv
module fault_ring
   import fault_ring_pkg::*;
#(
   parameter int NUM_REC = 4,
   localparam int IDX_W  = $clog2(NUM_REC),
   localparam int ADDR_W = $clog2(REC_BASE + REC_WORDS * NUM_REC)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 flt_valid,
   input  logic [PAYLOAD_W-1:0] flt_payload,
   input  logic                 reg_we,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [WORD_W-1:0]    reg_wdata,
   output logic [WORD_W-1:0]    reg_rdata,
   output logic                 irq_o
);
   if (NUM_REC < 2 || NUM_REC > MAX_REC) begin : g_bad_depth
      $error("fault_ring: NUM_REC must lie in 2..64");
   end
   if (STS_IDX_LSB + IDX_W > FLAG_BIT) begin : g_bad_status
      $error("fault_ring: first-index field does not fit in the status word");
   end

   logic                 rec_en;
   logic [IDX_W-1:0]     wr_idx;
   logic [NUM_REC-1:0]   valid;
   logic [NUM_REC-1:0]   clr_vec;
   logic [PAYLOAD_W-1:0] payload [NUM_REC];
   logic                 sts_wr;
   logic                 ovf_w1c;
   logic                 ovf;
   logic                 pend;
   logic [IDX_W-1:0]     first_idx;

   fault_ring_store #(.NUM_REC(NUM_REC)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (rec_en),
      .wr_idx     (wr_idx),
      .wr_payload (flt_payload),
      .clr_vec    (clr_vec),
      .valid_o    (valid),
      .payload_o  (payload)
   );

   fault_ring_ctrl #(.NUM_REC(NUM_REC)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .flt_valid (flt_valid),
      .valid_i   (valid),
      .clr_vec   (clr_vec),
      .sts_wr    (sts_wr),
      .ovf_w1c   (ovf_w1c),
      .rec_en    (rec_en),
      .wr_idx    (wr_idx),
      .ovf       (ovf),
      .pend      (pend),
      .first_idx (first_idx),
      .irq       (irq_o)
   );

   fault_ring_regs #(.NUM_REC(NUM_REC)) u_regs (
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .valid_i   (valid),
      .payload_i (payload),
      .ovf       (ovf),
      .pend      (pend),
      .first_idx (first_idx),
      .reg_rdata (reg_rdata),
      .clr_vec   (clr_vec),
      .sts_wr    (sts_wr),
      .ovf_w1c   (ovf_w1c)
   );
endmodule

// File: rtl/fault_ring_chk.sv
module fault_ring_chk #(
   parameter int NUM_REC = 4,
   localparam int IDX_W = $clog2(NUM_REC)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flt_valid,
   input logic             rec_en,
   input logic [IDX_W-1:0] wr_idx,
   input logic             irq,
   input logic             ovf,
   input logic             pend
);
   // R3
   idx_hold_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_valid && !rec_en) |=> $stable(wr_idx));
   // R3
   idx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flt_valid |=> $stable(wr_idx));
   // R3
   idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_en |=> (int'(wr_idx) == ((int'($past(wr_idx)) + 1) % NUM_REC)));
   // R8
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(rec_en));
   // R5
   ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> ($past(flt_valid) && !$past(rec_en)));
   // R6
   pend_after_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flt_valid |=> pend);
endmodule

bind fault_ring fault_ring_chk #(.NUM_REC(NUM_REC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .flt_valid (flt_valid),
   .rec_en    (rec_en),
   .wr_idx    (wr_idx),
   .irq       (irq_o),
   .ovf       (ovf),
   .pend      (pend)
);

// File: tb/fault_ring_bench.sv
module fault_ring_bench;
   localparam int N  = 4;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flt_valid = 1'b0;
   logic [126:0]  flt_payload = '0;
   logic          reg_we = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          irq_o;

   int nvec = 0;
   int nerr = 0;

   logic [126:0] mpay [N];
   bit           mv   [N];
   int           midx, mfirst;
   bit           movf, mout, mirq;
   bit [31:0]    lf = 32'h1234_5678;

   always #5 clk = ~clk;

   fault_ring #(.NUM_REC(N)) u_fault_ring (
      .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_payload(flt_payload),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_o(irq_o));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      reg_addr = AW'(a);
      #1;
      d = reg_rdata;
   endtask

   function automatic logic [126:0] mkpay(input int n);
      logic [31:0] b;
      b = 32'(n) * 32'h9E37_79B9 + 32'h0101_0101;
      return {b[30:0] ^ 31'h2A, b ^ 32'h5555_0000, ~b, b};
   endfunction

   function automatic bit [31:0] rnd();
      lf ^= lf << 13;
      lf ^= lf >> 17;
      lf ^= lf << 5;
      return lf;
   endfunction

   // full comparison of status and every record against the model
   task automatic verify_all();
      logic [31:0] d;
      bit pend;
      pend = 0;
      for (int s = 0; s < N; s++) if (mv[s]) pend = 1;
      rd(0, d);
      chk("R5 overflow", 32'(d[0]), 32'(movf));
      chk("R6 pending", 32'(d[1]), 32'(pend));
      chk("R7 first index", 32'(d[9:8]), 32'(mfirst));
      for (int s = 0; s < N; s++) begin
         for (int w = 0; w < 3; w++) begin
            rd(4 + 4*s + w, d);
            chk("R2 word", d, mpay[s][w*32 +: 32]);
         end
         rd(4 + 4*s + 3, d);
         chk("R2 flag word", d, {mv[s], mpay[s][126:96]});
      end
   endtask

   // one active cycle; called right after a falling edge
   task automatic step(input bit f, input logic [126:0] p, input bit w,
                       input int a, input logic [31:0] d);
      bit clr, stsw, oeff, drop;
      int cs;
      clr  = w && a >= 4 && ((a - 4) % 4 == 3) && d[31] && ((a - 4) / 4 < N);
      cs   = (a - 4) / 4;
      stsw = w && a == 0;
      if (clr) mv[cs] = 0;
      oeff = mout && !stsw;
      mirq = 0;
      drop = 0;
      if (f) begin
         if (mv[midx]) drop = 1;
         else begin
            mv[midx] = 1;
            mpay[midx] = p;
            if (!oeff) begin
               mirq = 1;
               mfirst = midx;
            end
            oeff = 1;
            midx = (midx + 1) % N;
         end
      end
      mout = oeff;
      if (drop) movf = 1;
      else if (stsw && d[0]) movf = 0;
      flt_valid   = f;
      flt_payload = p;
      reg_we      = w;
      reg_addr    = AW'(a);
      reg_wdata   = d;
      @(posedge clk);
      #1;
      chk("R8 irq", 32'(irq_o), 32'(mirq));
      flt_valid = 0;
      reg_we    = 0;
      verify_all();
      @(negedge clk);
   endtask

   initial begin
      logic [31:0] d;
      for (int s = 0; s < N; s++) begin
         mpay[s] = '0;
         mv[s]   = 0;
      end
      midx = 0; mfirst = 0; movf = 0; mout = 0; mirq = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1 irq", 32'(irq_o), 32'd0);
      rd(1, d);
      chk("R1 capability", d, 32'(N));
      rd(0, d);
      chk("R1 status", d, 32'd0);
      verify_all();
      @(negedge clk);

      // fill the ring; only the first recording interrupts
      for (int i = 1; i <= N; i++) step(1, mkpay(i), 0, 0, 0);
      rd(4 + 4*3, d);
      chk("R3 last slot", d, mkpay(N)[31:0]);   // R3: slots filled in order
      @(negedge clk);

      // R4: full ring drops
      step(1, mkpay(50), 0, 0, 0);
      rd(0, d);
      chk("R4 overflow on full", 32'(d[0]), 32'd1);
      @(negedge clk);

      // R4: slot 2 freed but the index sits on valid slot 0
      step(0, '0, 1, 4 + 4*2 + 3, 32'h8000_0000);
      step(1, mkpay(51), 0, 0, 0);
      rd(4 + 4*2 + 3, d);
      chk("R4 free slot untouched", 32'(d[31]), 32'd0);
      rd(4, d);
      chk("R4 indexed slot kept", d, mkpay(1)[31:0]);
      @(negedge clk);

      // R9: writes that must not change slot 0
      step(0, '0, 1, 4, 32'hFFFF_FFFF);
      step(0, '0, 1, 7, 32'h7FFF_FFFF);
      rd(7, d);
      chk("R9 flag kept", d, {1'b1, mkpay(1)[126:96]});
      @(negedge clk);

      // R10: clear and fault on the indexed slot in one cycle
      step(1, mkpay(52), 1, 7, 32'h8000_0000);
      rd(4, d);
      chk("R10 same-cycle record", d, mkpay(52)[31:0]);
      rd(0, d);
      chk("R10 no overflow change", 32'(d[0]), 32'd1);
      @(negedge clk);

      // R5/R8: acknowledge, then the next recording interrupts again
      step(0, '0, 1, 0, 32'h0000_0001);
      step(0, '0, 1, 4 + 4*1 + 3, 32'h8000_0000);
      step(1, mkpay(53), 0, 0, 0);
      rd(0, d);
      chk("R7 first index after ack", 32'(d[9:8]), 32'd1);
      @(negedge clk);

      // R8: ack in the same cycle as a recording still interrupts
      step(0, '0, 1, 4 + 4*2 + 3, 32'h8000_0000);
      step(1, mkpay(54), 1, 0, 32'h0);

      // pseudo-random sweep over faults, clears and status writes
      for (int i = 0; i < 600; i++) begin
         bit [31:0] r;
         bit f, w;
         int a;
         logic [31:0] dd;
         r  = rnd();
         f  = r[0] | r[1];
         w  = r[2] | r[3];
         a  = r[6:4] == 0 ? 0 : 4 + 4*int'(r[9:8]) + (r[7] ? 3 : int'(r[11:10]));
         dd = {r[12] | r[13], rnd()[30:1], r[14]};
         step(f, mkpay(100 + i), w, a, dd);
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      #2_000_000;
      nerr++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule